// File: doc/BRIEF.md
# Keyboard Matrix Walking-Zero Scanner

This block stands in for a host processor that polls a keyboard matrix once per frame. An internal frame timer fires every `FRAME_CLKS` clock cycles. When it fires and no pass is running, the block walks a single low bit across an active-low select bus of `NUM_COLS + NUM_SWITCHES` lines. The walk goes from the lowest line upward, and each line is held low for `DWELL_INSNS` instruction periods of `CLKS_PER_INSN` clocks each. The lower lines drive the key columns. The top lines select the encoded slide-switch inputs.

The row sources already OR together whatever is selected onto a 4-bit return bus. The scanner samples that bus once per step, in the last clock of the step's dwell. It then presents the sample with the step number and a one-clock valid strobe. Between passes every select line rests high. A timer pulse that lands while a pass is running, including its very last cycle, is dropped. The defaults model a 1.4 us instruction period at 125 MHz, 32 instructions per line, and a 28 ms frame.

Top module: `kbd_scan_walker`

## Requirements
- R1: After reset and whenever no pass is running, every bit of `selN` is 1 and `rowValid` is 0.
- R2: The frame timer pulses in cycle `FRAME_CLKS-1` after reset release and every `FRAME_CLKS` cycles after that. A pulse that finds the block idle makes `selN[0]` go low in the next cycle.
- R3: During a pass exactly one `selN` bit is 0, and it moves upward one position per step: bits 0 to 7 are key columns, bits 8 and 9 are the switch selects.
- R4: Each select bit stays low for exactly `CLKS_PER_INSN*DWELL_INSNS` consecutive clocks.
- R5: `rowIn` is sampled only in the last clock of each step's dwell. Its value in any other clock has no effect on `rowOut`.
- R6: `rowValid` pulses high for one clock, in the clock after the sampling clock. At the same time `rowStep` carries the step number in binary (0 to 9) and `rowOut` carries the sampled row.
- R7: A pass yields exactly ten `rowValid` pulses. `selN` returns to all ones in the clock after step 9's dwell ends.
- R8: A timer pulse during a pass, including the final clock of step 9, is ignored. The next pass starts after the first later timer pulse that finds the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rowIn | input | 4 | OR of the row sources chosen by `selN` |
| selN | output | 10 | Active-low select bus; the low bit walks upward |
| rowValid | output | 1 | One-clock strobe marking a new row sample |
| rowStep | output | 4 | Step number of the sample |
| rowOut | output | 4 | Sampled row value |

## Verification
The frame timer pulse and the end-of-pass capture can fall in the same clock. A second instance has a frame period that divides the pass length exactly, so its timer fires both mid-pass and on the final dwell clock of step 9. The bench judges that collision by the timing of the row strobes. The first pass must give ten strobes ending at the expected cycle. The next pass must start only one full frame later, with the select bus all high in between. Sampling is also checked against row values that change on every non-sampling clock.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

  typedef struct packed {
    logic start;    // begin a pass at step 0
    logic capture;  // last clock of a dwell: sample the row
    logic advance;  // move the low bit up one line
    logic finish;   // final step done: release all lines
  } scan_strobe_t;

endpackage

// File: rtl/kscan_frame_timer.sv
module kscan_frame_timer #(
  parameter int FRAME_CLKS = 3_500_000
) (
  input  logic clk,
  input  logic rst,
  output logic frameTick
);
  localparam int FRAME_W = $clog2(FRAME_CLKS + 1);
  localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAME_CLKS - 1);

  logic [FRAME_W-1:0] frameCnt;

  always_ff @(posedge clk) begin
    if (rst) frameCnt <= '0;
    else if (frameCnt == FRAME_LAST) frameCnt <= '0;
    else frameCnt <= frameCnt + 1'b1;
  end

  assign frameTick = (frameCnt == FRAME_LAST);

endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int NUM_STEPS     = 10,
  parameter int CLKS_PER_INSN = 175,
  parameter int DWELL_INSNS   = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frameTick,
  output scan_strobe_t                 strobe,
  output logic [$clog2(NUM_STEPS)-1:0] stepIdx,
  output logic                         busy
);
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam int PRE_W  = $clog2(CLKS_PER_INSN + 1);
  localparam int INSN_W = $clog2(DWELL_INSNS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(CLKS_PER_INSN - 1);
  localparam logic [INSN_W-1:0] INSN_LAST = INSN_W'(DWELL_INSNS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [INSN_W-1:0] insnCnt;
  logic              insnEnd;
  logic              dwellEnd;

  assign insnEnd  = (preCnt == PRE_LAST);
  assign dwellEnd = insnEnd && (insnCnt == INSN_LAST);

  always_comb begin
    strobe.start   = frameTick && !busy;
    strobe.capture = busy && dwellEnd;
    strobe.advance = strobe.capture && (stepIdx != STEP_LAST);
    strobe.finish  = strobe.capture && (stepIdx == STEP_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      stepIdx <= '0;
      preCnt  <= '0;
      insnCnt <= '0;
    end else if (strobe.start) begin
      busy    <= 1'b1;
      stepIdx <= '0;
      preCnt  <= '0;
      insnCnt <= '0;
    end else if (busy) begin
      if (insnEnd) begin
        preCnt  <= '0;
        insnCnt <= dwellEnd ? '0 : insnCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      if (strobe.advance) stepIdx <= stepIdx + 1'b1;
      if (strobe.finish)  busy    <= 1'b0;
    end
  end

  initial begin
    a_r6_dwell_min : assert (CLKS_PER_INSN * DWELL_INSNS >= 2)
      else $error("dwell must span at least two clocks");
  end

  a_r2_idle_start : assert property (@(posedge clk) disable iff (rst)
    (frameTick && !busy) |=> (busy && stepIdx == '0));

  a_r8_mid_ignore : assert property (@(posedge clk) disable iff (rst)
    (frameTick && busy && !strobe.capture) |=> (busy && $stable(stepIdx)));

  a_r8_final_ignore : assert property (@(posedge clk) disable iff (rst)
    (frameTick && strobe.finish) |=> !busy);

endmodule

// File: rtl/kscan_dpath.sv
module kscan_dpath
  import kscan_pkg::*;
#(
  parameter int NUM_STEPS = 10,
  parameter int ROW_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  scan_strobe_t                 strobe,
  input  logic [$clog2(NUM_STEPS)-1:0] stepIdx,
  input  logic [ROW_W-1:0]             rowIn,
  output logic [NUM_STEPS-1:0]         selN,
  output logic                         rowValid,
  output logic [$clog2(NUM_STEPS)-1:0] rowStep,
  output logic [ROW_W-1:0]             rowOut
);
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam logic [NUM_STEPS-1:0] SEL_IDLE  = '1;
  localparam logic [NUM_STEPS-1:0] SEL_FIRST = ~NUM_STEPS'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      selN <= SEL_IDLE;
    end else if (strobe.start) begin
      selN <= SEL_FIRST;
    end else if (strobe.advance) begin
      selN <= {selN[NUM_STEPS-2:0], 1'b1};
    end else if (strobe.finish) begin
      selN <= SEL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowValid <= 1'b0;
      rowStep  <= '0;
      rowOut   <= '0;
    end else begin
      rowValid <= strobe.capture;
      if (strobe.capture) begin
        rowStep <= stepIdx;
        rowOut  <= rowIn;
      end
    end
  end

  a_r3_single_low : assert property (@(posedge clk) disable iff (rst)
    $onehot0(~selN));

  a_r4_hold : assert property (@(posedge clk) disable iff (rst)
    !(strobe.start || strobe.advance || strobe.finish) |=> $stable(selN));

  a_r6_one_clock : assert property (@(posedge clk) disable iff (rst)
    rowValid |=> !rowValid);

  a_r6_step_range : assert property (@(posedge clk) disable iff (rst)
    rowValid |-> (rowStep < STEP_W'(NUM_STEPS)));

  a_r7_release : assert property (@(posedge clk) disable iff (rst)
    strobe.finish |=> (selN == SEL_IDLE));

endmodule

// File: rtl/kbd_scan_walker.sv
module kbd_scan_walker
  import kscan_pkg::*;
#(
  parameter int NUM_COLS      = 8,
  parameter int NUM_SWITCHES  = 2,
  parameter int ROW_W         = 4,
  parameter int CLKS_PER_INSN = 175,
  parameter int DWELL_INSNS   = 32,
  parameter int FRAME_CLKS    = 3_500_000
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic [ROW_W-1:0]                                rowIn,
  output logic [NUM_COLS+NUM_SWITCHES-1:0]                selN,
  output logic                                            rowValid,
  output logic [$clog2(NUM_COLS+NUM_SWITCHES)-1:0]        rowStep,
  output logic [ROW_W-1:0]                                rowOut
);
  localparam int NUM_STEPS = NUM_COLS + NUM_SWITCHES;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  logic              frameTick;
  logic              busy;
  logic [STEP_W-1:0] stepIdx;
  scan_strobe_t      strobe;

  kscan_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
    .clk(clk), .rst(rst), .frameTick(frameTick)
  );

  kscan_ctrl #(
    .NUM_STEPS(NUM_STEPS), .CLKS_PER_INSN(CLKS_PER_INSN), .DWELL_INSNS(DWELL_INSNS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .frameTick(frameTick),
    .strobe(strobe), .stepIdx(stepIdx), .busy(busy)
  );

  kscan_dpath #(.NUM_STEPS(NUM_STEPS), .ROW_W(ROW_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .stepIdx(stepIdx), .rowIn(rowIn),
    .selN(selN), .rowValid(rowValid), .rowStep(rowStep), .rowOut(rowOut)
  );

  a_r1_idle_high : assert property (@(posedge clk) disable iff (rst)
    !busy |-> (selN == '1));

endmodule

// File: tb/kbd_scan_walker_test.sv
module kbd_scan_walker_test;
  localparam int P = 2, I = 4, D = P * I, STEPS = 10, FA = 100, FB = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0] rowInA = 4'hF, rowInB = 4'hF;
  logic [9:0] selA, selB;
  logic       vldA, vldB;
  logic [3:0] stpA, stpB, rowA, rowB;

  kbd_scan_walker #(.CLKS_PER_INSN(P), .DWELL_INSNS(I), .FRAME_CLKS(FA)) uut (
    .clk(clk), .rst(rst), .rowIn(rowInA), .selN(selA),
    .rowValid(vldA), .rowStep(stpA), .rowOut(rowA));

  kbd_scan_walker #(.CLKS_PER_INSN(P), .DWELL_INSNS(I), .FRAME_CLKS(FB)) uutB (
    .clk(clk), .rst(rst), .rowIn(rowInB), .selN(selB),
    .rowValid(vldB), .rowStep(stpB), .rowOut(rowB));

  int cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int seqA[$];
  int pulseB[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int step, input int scanNo);
    return 4'((step * 7 + scanNo * 5 + 3) % 16);
  endfunction

  // Cycle n = clocks since reset release
  function automatic void model(input int n, input int f, output bit act,
                                output int step, output int phase, output int scanNo);
    int s;
    act = 0; step = 0; phase = 0; scanNo = 0;
    if (n < f) return;
    s = f;
    while (n >= s + STEPS * D) begin
      s = ((s + STEPS * D + 1 + f - 1) / f) * f;
      scanNo++;
    end
    if (n >= s) begin
      act = 1; step = (n - s) / D; phase = (n - s) % D;
    end
  endfunction

  task automatic evalInst(input int n, input int f, input string tag,
                          input logic [9:0] sel, input logic vld,
                          input logic [3:0] stp, input logic [3:0] row,
                          output logic [3:0] drive);
    bit act, act1;
    int st, ph, sn, st1, ph1, sn1;
    logic [9:0] expSel;
    bit expVld;
    model(n, f, act, st, ph, sn);
    expSel = act ? ~(10'b1 << st) : 10'h3FF;
    chk(sel == expSel, tag, "selN", int'(sel), int'(expSel));
    model(n - 1, f, act1, st1, ph1, sn1);
    expVld = (n >= 1) && act1 && (ph1 == D - 1);
    chk(vld == expVld, "R6", "rowValid", int'(vld), int'(expVld));
    if (expVld && vld) begin
      chk(stp == 4'(st1), "R6", "rowStep", int'(stp), st1);
      chk(row == pat(st1, sn1), "R5", "rowOut", int'(row), int'(pat(st1, sn1)));
    end
    if (act && ph == D - 1) drive = pat(st, sn);
    else if (act) drive = ~pat(st, sn);
    else drive = 4'(n);
  endtask

  task automatic tick1();
    logic [3:0] dA, dB;
    int n;
    @(negedge clk);
    n = cyc;
    evalInst(n, FA, "R4", selA, vldA, stpA, rowA, dA);
    evalInst(n, FB, "R8", selB, vldB, stpB, rowB, dB);
    if (vldA) seqA.push_back(int'(stpA));
    if (vldB) pulseB.push_back(n);
    rowInA = dA;
    rowInB = dB;
  endtask

  task automatic runTo(input int last);
    while (cyc < last) tick1();
  endtask

  task automatic t_reset_idle();
    repeat (3) begin
      @(negedge clk);
      chk(selA == 10'h3FF, "R1", "selN in reset", int'(selA), 10'h3FF);
      chk(vldA == 1'b0, "R1", "rowValid in reset", int'(vldA), 0);
    end
    rst = 1'b0;
    runTo(FA - 1);
    chk(selA == 10'h3FF, "R2", "selN before first tick", int'(selA), 10'h3FF);
    tick1();
    chk(selA == 10'h3FE, "R2", "selN after first tick", int'(selA), 10'h3FE);
  endtask

  task automatic checkPass(input int endCyc);
    runTo(endCyc);
    chk(seqA.size() == STEPS, "R7", "pulses per pass", seqA.size(), STEPS);
    foreach (seqA[i]) chk(seqA[i] == i, "R3", "step order", seqA[i], i);
    seqA.delete();
  endtask

  task automatic t_first_pass();
    seqA.delete();
    checkPass(FA + STEPS * D + 2);
    chk(selA == 10'h3FF, "R7", "selN after pass", int'(selA), 10'h3FF);
  endtask

  task automatic t_later_passes();
    for (int k = 2; k <= 4; k++) begin
      runTo(k * FA - 1);
      seqA.delete();
      checkPass(k * FA + STEPS * D + 2);
    end
  endtask

  task automatic t_collision();
    chk(pulseB.size() >= 11, "R8", "second-instance pulse count", pulseB.size(), 11);
    if (pulseB.size() >= 11) begin
      chk(pulseB[0] == FB + D, "R8", "first pulse cycle", pulseB[0], FB + D);
      chk(pulseB[9] == FB + STEPS * D, "R8", "tenth pulse cycle", pulseB[9], FB + STEPS * D);
      chk(pulseB[10] == 4 * FB + D, "R8", "restart pulse cycle", pulseB[10], 4 * FB + D);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_idle();
    t_first_pass();
    t_later_passes();
    t_collision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule